// File: doc/BRIEF.md
# Integer and Half-Step Clock Divider

This block produces a clock whose period is a programmable multiple of an input clock. The multiple is either a whole number N or N plus one half. The output keeps its high and low times within one input half-cycle of each other. A counter running on rising input edges produces one phase signal. A register clocked on falling input edges produces a second phase signal. The output is the OR of the two, which places output edges on either input edge. This is how odd and half-step factors keep a near 50% duty cycle.

The divide word is decoded into one of three named modes. MODE_EVEN covers an even whole factor and uses only the rising-edge phase. MODE_ODD covers an odd whole factor: the falling-edge phase stretches each high time by half an input period. MODE_HALF covers a half-step factor: the counter spans two output periods, and every second output period begins on a falling input edge. The only transition between modes is a reload. The decoded settings are taken over when the counter wraps from its terminal count to zero, and at no other time. Reset returns the block to a divide-by-two setting with the output low.

Top module: `hsdiv_top`

## Requirements
- R1: With an even whole factor N, the output period is 2N input half-cycles, the high time is exactly N half-cycles, and every output rising edge coincides with a rising input edge.
- R2: With an odd whole factor N, the output period is 2N input half-cycles, the high time is exactly N half-cycles, and every output rising edge coincides with a rising input edge.
- R3: With a factor N+0.5, every output period is 2N+1 input half-cycles. Its high and low times differ by at most one half-cycle. Consecutive output rising edges alternate between rising and falling input edges.
- R4: The divide word is encoded as follows: bit 0 selects the extra half step, and bits [WORD_W-1:1] hold the whole part N.
- R5: A word whose whole part is 0 or 1 divides by exactly 2, whatever its bit 0. The output period is 4 half-cycles and the high time is 2 half-cycles.
- R6: While the active-low reset is asserted, the output is low. Asserting reset during operation drives the output low at once. After release, the output stays low through the first rising input edge.
- R7: A change of the divide word takes effect only at the next counter wrap. The output period already in progress completes with the old factor, and the following period uses the new one.
- R8: The counter advances by one on each rising input edge, never passes its terminal count, and returns to zero after reaching it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_word | input | WORD_W | Divide factor: bit 0 is the half step, upper bits are the whole part |
| clk_out | output | 1 | Divided clock |

## Verification
The hardest case to reach from the ports is a divide word that changes partway through an output period. The change has to land after the counter has left zero but before it wraps. Only then does a reload at the wrong moment show up as a wrong period. The stimulus waits for an output rising edge, moves the word two time units later during the first counter cycle, and measures the old and the new period around the wrap. The falling-edge start of alternate half-step periods is checked by recording which input edge each output rising edge follows.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;
    // Operating mode chosen from the divide word
    typedef enum logic [1:0] {
        MODE_EVEN = 2'd0,
        MODE_ODD  = 2'd1,
        MODE_HALF = 2'd2
    } div_mode_e;
endpackage

// File: rtl/hsdiv_decode.sv
module hsdiv_decode
    import hsdiv_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic [WORD_W-1:0] word,
    output div_mode_e         mode,
    output logic [WORD_W-1:0] last,
    output logic [WORD_W-1:0] lim,
    output logic [WORD_W-1:0] q1_lo,
    output logic [WORD_W-1:0] q1_hi
);
    localparam int CW = WORD_W;

    logic [CW-1:0] n_eff;
    logic          half_eff;

    always_comb begin
        n_eff    = word >> 1;
        half_eff = word[0];
        // factors below two collapse to divide-by-two
        if (n_eff < CW'(2)) begin
            n_eff    = CW'(2);
            half_eff = 1'b0;
        end
        if (half_eff)      mode = MODE_HALF;
        else if (n_eff[0]) mode = MODE_ODD;
        else               mode = MODE_EVEN;

        last  = n_eff - CW'(1);
        lim   = n_eff >> 1;
        q1_lo = '0;
        q1_hi = '0;
        unique case (mode)
            MODE_EVEN: begin
                last = n_eff - CW'(1);
                lim  = n_eff >> 1;
            end
            MODE_ODD: begin
                last  = n_eff - CW'(1);
                lim   = n_eff >> 1;
                q1_lo = (n_eff >> 1) - CW'(1);
                q1_hi = (n_eff >> 1) - CW'(1);
            end
            MODE_HALF: begin
                last  = {n_eff[CW-2:0], 1'b0};
                lim   = (n_eff + CW'(1)) >> 1;
                q1_lo = n_eff;
                q1_hi = n_eff + ((n_eff + CW'(1)) >> 1) - CW'(1);
            end
            default: begin
                last = n_eff - CW'(1);
            end
        endcase
    end
endmodule

// File: rtl/hsdiv_rise.sv
module hsdiv_rise
    import hsdiv_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  div_mode_e         mode_d,
    input  logic [WORD_W-1:0] last_d,
    input  logic [WORD_W-1:0] lim_d,
    input  logic [WORD_W-1:0] lo_d,
    input  logic [WORD_W-1:0] hi_d,
    output logic [WORD_W-1:0] cnt_q,
    output div_mode_e         mode_q,
    output logic [WORD_W-1:0] lo_q,
    output logic [WORD_W-1:0] hi_q,
    output logic              q0
);
    localparam int CW = WORD_W;

    logic [CW-1:0] last_q, lim_q;
    logic [CW-1:0] cnt_nx, lim_nx;
    logic          wrap;

    always_comb begin
        wrap   = (cnt_q == last_q);
        cnt_nx = wrap ? '0 : cnt_q + CW'(1);
        lim_nx = wrap ? lim_d : lim_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= CW'(1);
            lim_q  <= CW'(1);
            lo_q   <= '0;
            hi_q   <= '0;
            mode_q <= MODE_EVEN;
            q0     <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            q0    <= (cnt_nx < lim_nx);
            if (wrap) begin
                last_q <= last_d;
                lim_q  <= lim_d;
                lo_q   <= lo_d;
                hi_q   <= hi_d;
                mode_q <= mode_d;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_q); // R8
    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != last_q) |=> (cnt_q == CW'($past(cnt_q) + CW'(1)))); // R8
    AST_CNT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == last_q) |=> (cnt_q == '0)); // R8
    AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (last_q != $past(last_q)) |-> ($past(cnt_q) == $past(last_q))); // R7
endmodule

// File: rtl/hsdiv_fall.sv
module hsdiv_fall
    import hsdiv_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cnt,
    input  div_mode_e         mode,
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    output logic              q1
);
    logic in_win;

    always_comb begin
        in_win = 1'b0;
        unique case (mode)
            MODE_EVEN: in_win = 1'b0;
            MODE_ODD,
            MODE_HALF: in_win = (cnt >= lo) && (cnt <= hi);
            default:   in_win = 1'b0;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q1 <= 1'b0;
        else        q1 <= in_win;
    end

    AST_EVEN_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_EVEN) |-> !q1); // R1
endmodule

// File: rtl/hsdiv_top.sv
module hsdiv_top
    import hsdiv_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] div_word,
    output logic              clk_out
);
    div_mode_e         mode_d, mode_q;
    logic [WORD_W-1:0] last_d, lim_d, lo_d, hi_d;
    logic [WORD_W-1:0] cnt_q, lo_q, hi_q;
    logic              q0, q1;

    hsdiv_decode #(.WORD_W(WORD_W)) i_decode (
        .word  (div_word),
        .mode  (mode_d),
        .last  (last_d),
        .lim   (lim_d),
        .q1_lo (lo_d),
        .q1_hi (hi_d)
    );

    hsdiv_rise #(.WORD_W(WORD_W)) i_rise (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .mode_d (mode_d),
        .last_d (last_d),
        .lim_d  (lim_d),
        .lo_d   (lo_d),
        .hi_d   (hi_d),
        .cnt_q  (cnt_q),
        .mode_q (mode_q),
        .lo_q   (lo_q),
        .hi_q   (hi_q),
        .q0     (q0)
    );

    hsdiv_fall #(.WORD_W(WORD_W)) i_fall (
        .clk   (clk_in),
        .rst_n (rst_n),
        .cnt   (cnt_q),
        .mode  (mode_q),
        .lo    (lo_q),
        .hi    (hi_q),
        .q1    (q1)
    );

    assign clk_out = q0 | q1;

    AST_HALF_DISJOINT: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mode_q == MODE_HALF) |-> !(q0 && q1)); // R3
    AST_RESET_QUIET: assert property (@(posedge clk_in)
        !rst_n |-> !clk_out); // R6
endmodule

// File: tb/test_hsdiv_top.sv
module test_hsdiv_top;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] div_word = 8'd14;
    logic              clk_out;

    int nchk = 0;
    int nfail = 0;

    int rise_hc [0:1023];
    int fall_hc [0:1023];
    bit rise_pos[0:1023];
    int rise_cnt = 0;
    int hc = 0;
    logic prev_out = 1'b0;

    hsdiv_top #(.WORD_W(WORD_W)) i_hsdiv_top (
        .clk_in   (clk),
        .rst_n    (rst_n),
        .div_word (div_word),
        .clk_out  (clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // record output edges, counted in input half-cycles
    always @(posedge clk or negedge clk) begin
        #1;
        hc++;
        if (clk_out === 1'b1 && prev_out === 1'b0 && rise_cnt < 1023) begin
            rise_hc[rise_cnt]  = hc;
            rise_pos[rise_cnt] = clk;
            rise_cnt++;
        end else if (clk_out === 1'b0 && prev_out === 1'b1 && rise_cnt > 0) begin
            fall_hc[rise_cnt-1] = hc;
        end
        prev_out = clk_out;
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rises(input int k);
        int target;
        target = rise_cnt + k;
        wait (rise_cnt >= target);
    endtask

    task automatic run_factor(input logic [WORD_W-1:0] w, input int nper, input string req);
        int n, h, per, base, p, hi;
        n = int'(w >> 1);
        h = int'(w[0]);
        if (n < 2) begin n = 2; h = 0; end
        per = (h != 0) ? 2*n + 1 : 2*n;
        div_word = w;
        wait_rises(3);
        base = rise_cnt - 1;
        wait_rises(nper);
        for (int j = 0; j < nper; j++) begin
            p  = rise_hc[base+j+1] - rise_hc[base+j];
            hi = fall_hc[base+j] - rise_hc[base+j];
            check(req, p, per);
            if (h == 0) begin
                check(req, hi, n);
                check(req, int'(rise_pos[base+j]), 1);
            end else begin
                check(req, int'((2*hi - per) <= 1 && (per - 2*hi) <= 1), 1);
                check(req, int'(rise_pos[base+j+1] != rise_pos[base+j]), 1);
            end
        end
    endtask

    task automatic test_reset_start;
        repeat (3) @(posedge clk);
        #2 check("R6", int'(clk_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2 check("R6", int'(clk_out), 0);
    endtask

    task automatic test_reload_timing;
        int i0;
        run_factor(8'd14, 2, "R2");
        wait_rises(1);
        i0 = rise_cnt - 1;
        #2 div_word = 8'd8;
        wait (rise_cnt >= i0 + 3);
        check("R7", rise_hc[i0+1] - rise_hc[i0], 14);
        check("R7", rise_hc[i0+2] - rise_hc[i0+1], 8);
    endtask

    task automatic test_reset_midrun;
        div_word = 8'd14;
        wait_rises(3);
        #2 rst_n = 1'b0;
        #1 check("R6", int'(clk_out), 0);
        @(posedge clk);
        #2 check("R6", int'(clk_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2 check("R6", int'(clk_out), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        test_reset_start();
        run_factor(8'd8,   4, "R1");
        run_factor(8'd20,  4, "R1");
        run_factor(8'd14,  4, "R2");
        run_factor(8'd6,   4, "R2");
        run_factor(8'd15,  6, "R3");
        run_factor(8'd5,   6, "R3");
        run_factor(8'd9,   6, "R3");
        run_factor(8'd201, 4, "R3");
        run_factor(8'd11,  4, "R4");
        run_factor(8'd10,  4, "R4");
        run_factor(8'd0,   3, "R5");
        run_factor(8'd1,   3, "R5");
        run_factor(8'd2,   3, "R5");
        run_factor(8'd3,   3, "R5");
        test_reload_timing();
        test_reset_midrun();
        run_factor(8'd15,  4, "R3");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule